// File: doc/BRIEF.md
# Execution Stage Issue Interlock

This block decides, cycle by cycle, whether the instruction sitting in the decode stage of a single-issue in-order pipeline may move into its first execution stage. The pipeline carries integer, load/store and floating-point instructions, and each class walks through its own chain of execution stages. Some stages with different names share hardware and must never be active together. The block keeps a short reservation table for the fixed-length stages (E, E1, E2, EM, EA). It also keeps a small state for the memory stages (MEM1, MEM2), because MEM1 ends only when the memory answers.

Each cycle the decode stage presents a valid flag, a class code and, for multi-cycle integer work, a cycle count. The block compares the full future stage pattern of that instruction against what is already reserved. If any slot would break a rule, it raises `stall`: the decode stage keeps its instruction and a bubble enters execution. Otherwise it raises `issue` and books the pattern. The block also reports the live stage occupancy. It flags the two forwarding paths, an integer result leaving E and a load result leaving MEM2, so the operand muxes can take a result before it reaches the register file.

Top module: `pipe_interlock`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `occ` is zero, both bypass flags are low, and no reservation survives.
- R2: Class codes are 0 integer, 1 integer multi-cycle, 2 load/store, 3 FP normal, 4 FP divide and 5 FP fused; codes 6 and 7 behave as 0. With `dec_valid` high, exactly one of `issue` and `stall` is high in the same cycle. With it low, both are low. An issued instruction occupies its first stage on the next cycle. `occ` bits are 0 E, 1 E1, 2 E2, 3 EM, 4 EA, 5 MEM1, 6 MEM2.
- R3: No two instructions share a stage. E is never active with E1, E2, EM or EA, and E1 is never active with EM or EA. An instruction that would collide is stalled until it would not.
- R4: A multi-cycle integer instruction holds E for `dec_ncyc` cycles. A count of 0 acts as 1 and counts above MAXM act as MAXM. An integer instruction that follows one with count N stalls N-1 cycles.
- R5: An FP divide holds E1 for DIV_CYC (14) cycles and then E2 for one cycle. An integer instruction decoded right after it stalls 14 cycles.
- R6: A load/store uses E for one cycle, then stays in MEM1 until a cycle with `mem_ready` high, then MEM2 for one cycle. A second load/store stalls while a load/store is in E or MEM1; back to back with memory ready, it stalls 2 cycles. Other classes are not held back by MEM1.
- R7: FP normal uses E1 then E2, one cycle each. FP fused uses E1, EM, EA, one cycle each. An FP normal behind a fused instruction stalls 2 cycles.
- R8: `byp_e_wb` is high in the last E cycle of an integer (non load/store) instruction only. `byp_mem2_wb` is high exactly when MEM2 is occupied.
- R9: Instructions whose patterns do not collide issue on consecutive cycles with no stall: FP normal after FP normal, FP normal after integer, and integer after a load/store that is waiting in MEM1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_class | input | 3 | Instruction class code |
| dec_ncyc | input | MW | E-stage cycle count for multi-cycle integer work |
| mem_ready | input | 1 | Memory completes the access in MEM1 this cycle |
| issue | output | 1 | Instruction advances at the next edge |
| stall | output | 1 | Instruction held in decode, bubble inserted |
| occ | output | 7 | Stage occupancy, one bit per stage |
| byp_e_wb | output | 1 | Integer result forwardable from the E-to-WB path |
| byp_mem2_wb | output | 1 | Load result forwardable from the MEM2-to-WB path |

## Verification
`issue` and `stall` are combinational in the decode cycle. The first stage of an issued instruction appears in `occ` one edge later. Each later stage follows one edge per stage cycle, and MEM2 appears one edge after a `mem_ready` cycle in MEM1. The bench therefore changes inputs and samples outputs at the falling edge. It counts stall cycles by sampling `issue` just after each falling edge, and reads occupancy at each falling edge from the one following the issuing edge, so every expected value is tied to a known number of edges.

// File: rtl/pipe_interlock.sv
module pipe_interlock #(
  parameter int HZ      = 32,
  parameter int DIV_CYC = 14,
  parameter int MAXM    = 8,
  parameter int MW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  input  logic [2:0]    dec_class,
  input  logic [MW-1:0] dec_ncyc,
  input  logic          mem_ready,
  output logic          issue,
  output logic          stall,
  output logic [6:0]    occ,
  output logic          byp_e_wb,
  output logic          byp_mem2_wb
);
  localparam logic [2:0] C_INT  = 3'd0;
  localparam logic [2:0] C_MUL  = 3'd1;
  localparam logic [2:0] C_LS   = 3'd2;
  localparam logic [2:0] C_FPN  = 3'd3;
  localparam logic [2:0] C_FDIV = 3'd4;
  localparam logic [2:0] C_FMA  = 3'd5;
  localparam logic [HZ-1:0] ONE     = HZ'(1);
  localparam logic [HZ-1:0] DIVMASK = (ONE << DIV_CYC) - ONE;
  localparam logic [HZ-1:0] DIVE2   = ONE << DIV_CYC;

  logic [HZ-1:0] r_e, r_e1, r_e2, r_em, r_ea, r_done;
  logic [HZ-1:0] p_e, p_e1, p_e2, p_em, p_ea, p_done;
  logic [HZ-1:0] f_e, f_e1, f_e2, f_em, f_ea;
  logic [MW-1:0] nclip;
  logic          ls_e, mem1_v, mem2_v, conflict, ls_block;

  assign nclip = (dec_ncyc == '0) ? MW'(1) :
                 (dec_ncyc > MW'(MAXM)) ? MW'(MAXM) : dec_ncyc;

  always_comb begin
    p_e = '0; p_e1 = '0; p_e2 = '0; p_em = '0; p_ea = '0; p_done = '0;
    case (dec_class)
      C_MUL: begin
        p_e    = (ONE << nclip) - ONE;
        p_done = ONE << (nclip - MW'(1));
      end
      C_LS:   p_e = ONE;
      C_FPN:  begin p_e1 = ONE; p_e2 = ONE << 1; end
      C_FDIV: begin p_e1 = DIVMASK; p_e2 = DIVE2; end
      C_FMA:  begin p_e1 = ONE; p_em = ONE << 1; p_ea = ONE << 2; end
      default: begin p_e = ONE; p_done = ONE; end
    endcase
  end

  assign f_e  = r_e  >> 1;
  assign f_e1 = r_e1 >> 1;
  assign f_e2 = r_e2 >> 1;
  assign f_em = r_em >> 1;
  assign f_ea = r_ea >> 1;

  assign conflict = |((p_e  & (f_e | f_e1 | f_e2 | f_em | f_ea)) |
                      (p_e1 & (f_e1 | f_e | f_em | f_ea)) |
                      (p_e2 & (f_e2 | f_e)) |
                      (p_em & (f_em | f_e | f_e1)) |
                      (p_ea & (f_ea | f_e | f_e1)));

  assign ls_block = (dec_class == C_LS) && (ls_e || mem1_v);
  assign stall    = dec_valid && (conflict || ls_block);
  assign issue    = dec_valid && !stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_e <= '0; r_e1 <= '0; r_e2 <= '0; r_em <= '0; r_ea <= '0; r_done <= '0;
      ls_e <= 1'b0; mem1_v <= 1'b0; mem2_v <= 1'b0;
    end else begin
      r_e    <= f_e  | (issue ? p_e  : '0);
      r_e1   <= f_e1 | (issue ? p_e1 : '0);
      r_e2   <= f_e2 | (issue ? p_e2 : '0);
      r_em   <= f_em | (issue ? p_em : '0);
      r_ea   <= f_ea | (issue ? p_ea : '0);
      r_done <= (r_done >> 1) | (issue ? p_done : '0);
      ls_e   <= issue && (dec_class == C_LS);
      mem1_v <= ls_e || (mem1_v && !mem_ready);
      mem2_v <= mem1_v && mem_ready;
    end
  end

  assign occ         = {mem2_v, mem1_v, r_ea[0], r_em[0], r_e2[0], r_e1[0], r_e[0]};
  assign byp_e_wb    = r_done[0];
  assign byp_mem2_wb = mem2_v;
endmodule

module pipe_interlock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dec_valid,
  input logic [2:0] dec_class,
  input logic       mem_ready,
  input logic       issue,
  input logic       stall,
  input logic [6:0] occ,
  input logic       byp_e_wb,
  input logic       byp_mem2_wb
);
  a_r2_one_of_two: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (issue != stall));
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !(issue || stall));
  a_r2_int_enters_e: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_class == 3'd0) |=> occ[0]);
  a_r3_e_alone: assert property (@(posedge clk) disable iff (!rst_n)
    occ[0] |-> (occ[4:1] == 4'b0));
  a_r3_e1_vs_fused: assert property (@(posedge clk) disable iff (!rst_n)
    occ[1] |-> (occ[4:3] == 2'b0));
  a_r5_div_enters_e1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_class == 3'd4) |=> occ[1]);
  a_r6_mem1_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (occ[5] && !mem_ready) |=> occ[5]);
  a_r6_mem2_source: assert property (@(posedge clk) disable iff (!rst_n)
    occ[6] |-> $past(occ[5] && mem_ready));
  a_r8_byp_in_e: assert property (@(posedge clk) disable iff (!rst_n)
    byp_e_wb |-> occ[0]);
  a_r8_byp_mem2: assert property (@(posedge clk) disable iff (!rst_n)
    byp_mem2_wb |-> $past(occ[5]));
endmodule

bind pipe_interlock pipe_interlock_chk i_chk (.*);

// File: tb/test_pipe_interlock.sv
module test_pipe_interlock;
  logic clk = 1'b0, rst_n = 1'b0, dec_valid = 1'b0, mem_ready = 1'b1;
  logic [2:0] dec_class = 3'd0;
  logic [3:0] dec_ncyc = 4'd0;
  logic issue, stall, byp_e_wb, byp_mem2_wb;
  logic [6:0] occ;
  int total = 0, bad = 0;
  bit done = 1'b0;

  pipe_interlock i_pipe_interlock (.clk, .rst_n, .dec_valid, .dec_class, .dec_ncyc,
    .mem_ready, .issue, .stall, .occ, .byp_e_wb, .byp_mem2_wb);

  always #4 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if ((occ[0] && occ[4:1] != 4'b0) || (occ[1] && occ[4:3] != 2'b0)) begin
      bad++;
      $display("FAIL R3 exclusion: actual=%0d expected=no conflict", occ);
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic drain(); dec_valid = 1'b0; repeat (20) step(); endtask

  task automatic send(input logic [2:0] c, input logic [3:0] n, output int st);
    dec_valid = 1'b1; dec_class = c; dec_ncyc = n; st = 0;
    #1;
    while (!issue) begin st++; @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) step();
    chk("R1", "occ in reset", occ, 0);
    chk("R1", "stall in reset", stall, 0);
    chk("R1", "bypass in reset", {byp_e_wb, byp_mem2_wb}, 0);
    rst_n = 1'b1;
    step();
    chk("R1", "occ after reset", occ, 0);
  endtask

  task automatic t_int();
    int st;
    send(3'd0, 4'd0, st);
    chk("R2", "int stalls", st, 0);
    chk("R2", "int in E", occ, 1);
    chk("R8", "int bypass", byp_e_wb, 1);
    dec_valid = 1'b0; step();
    chk("R2", "int gone", occ, 0);
    send(3'd7, 4'd0, st);
    chk("R2", "code 7 as int", occ, 1);
    drain();
  endtask

  task automatic mul_len(input logic [3:0] n, input int exp);
    int st, ec = 0, bp = -1;
    send(3'd1, n, st);
    dec_valid = 1'b0;
    for (int k = 0; k < 12; k++) begin
      ec += occ[0];
      if (byp_e_wb) bp = k;
      step();
    end
    chk("R4", "mul E cycles", ec, exp);
    chk("R8", "mul bypass slot", bp, exp - 1);
  endtask

  task automatic t_mul();
    int st, st2;
    mul_len(4'd4, 4);
    mul_len(4'd0, 1);
    mul_len(4'd15, 8);
    send(3'd1, 4'd3, st);
    send(3'd0, 4'd0, st2);
    chk("R4", "int after mul3 stalls", st2, 2);
    drain();
  endtask

  task automatic t_div();
    int st, st2, e1c = 0, e2c = 0, e2at = -1;
    send(3'd4, 4'd0, st);
    send(3'd0, 4'd0, st2);
    chk("R5", "int after div stalls", st2, 14);
    chk("R5", "int alone in E", occ, 1);
    drain();
    send(3'd4, 4'd0, st);
    dec_valid = 1'b0;
    for (int k = 0; k < 18; k++) begin
      e1c += occ[1];
      e2c += occ[2];
      if (occ[2]) e2at = k;
      step();
    end
    chk("R5", "div E1 cycles", e1c, 14);
    chk("R5", "div E2 cycles", e2c, 1);
    chk("R5", "div E2 slot", e2at, 14);
  endtask

  task automatic t_fp();
    int st, st2;
    send(3'd3, 4'd0, st);
    send(3'd3, 4'd0, st2);
    chk("R9", "fp after fp stalls", st2, 0);
    chk("R7", "fp pair E1+E2", occ, 6);
    drain();
    send(3'd5, 4'd0, st);
    dec_valid = 1'b0;
    chk("R7", "fused E1", occ, 2); step();
    chk("R7", "fused EM", occ, 8); step();
    chk("R7", "fused EA", occ, 16); step();
    chk("R7", "fused done", occ, 0);
    send(3'd5, 4'd0, st);
    send(3'd3, 4'd0, st2);
    chk("R7", "fp after fused stalls", st2, 2);
    drain();
    send(3'd3, 4'd0, st);
    send(3'd0, 4'd0, st2);
    chk("R3", "int after fp stalls", st2, 1);
    drain();
    send(3'd5, 4'd0, st);
    send(3'd0, 4'd0, st2);
    chk("R3", "int after fused stalls", st2, 2);
    drain();
    send(3'd0, 4'd0, st);
    send(3'd3, 4'd0, st2);
    chk("R9", "fp after int stalls", st2, 0);
    drain();
  endtask

  task automatic t_ls();
    int st, st2;
    mem_ready = 1'b0;
    send(3'd2, 4'd0, st);
    dec_valid = 1'b0;
    chk("R6", "ls in E", occ, 1);
    chk("R8", "ls no E bypass", byp_e_wb, 0);
    step(); chk("R6", "ls MEM1", occ, 32);
    step(); chk("R6", "ls MEM1 held", occ, 32);
    mem_ready = 1'b1;
    step();
    chk("R6", "ls MEM2", occ, 64);
    chk("R8", "mem2 bypass", byp_mem2_wb, 1);
    step();
    chk("R6", "ls done", occ, 0);
    chk("R8", "mem2 bypass off", byp_mem2_wb, 0);
    send(3'd2, 4'd0, st);
    send(3'd2, 4'd0, st2);
    chk("R6", "ls after ls stalls", st2, 2);
    drain();
    mem_ready = 1'b0;
    send(3'd2, 4'd0, st);
    send(3'd0, 4'd0, st2);
    chk("R9", "int behind waiting ls stalls", st2, 0);
    mem_ready = 1'b1;
    drain();
  endtask

  initial begin
    #(8 * 20000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    t_reset();
    t_int();
    t_mul();
    t_div();
    t_fp();
    t_ls();
    total++;
    report();
  end
endmodule